// File: doc/BRIEF.md
# JTAG Debug Mailbox

This block is a two-way word mailbox between an external debugger working over a JTAG test access port and a processor running on its own core clock. An external TAP controller supplies select, capture, shift and update strobes. The debugger then reaches the block through one 38-bit scan register. Every scan carries a direction flag, a register address and a 32-bit word. Nothing acts on the contents until the update strobe arrives. At that point the block decodes the address. Address 0x05 selects the data mailbox and address 0x04 selects a read-only status word.

In the debugger-to-core direction, the debugger writes a word. The core sees it with a valid flag and takes it with a one-cycle acknowledge. In the core-to-debugger direction, the core posts a word with a write strobe. The debugger reads it with a read request followed by a second scan. The debugger polls two flags in the status word. R means its last word has not been taken yet. W means a core word is waiting to be read. Each flag event crosses between the TCK and core clocks as a toggle through a two-flop synchronizer, so every event is seen exactly once.

Top module: `dcc_mailbox`

## Requirements
- R1: The scan register is 38 bits long and is only active while `drSelect` is high. On each shift cycle it moves one place toward bit 0. `tdi` enters bit 37 and `tdo` always shows bit 0. Bit layout: bits 31:0 data, bits 36:32 address, bit 37 direction (1 = write, 0 = read).
- R2: An update with direction 1 and address 0x05, while R is 0, stores the data field. Within three core clock edges the word appears on `coreRxData` and `coreRxValid` rises. R (status bit 0) reads as 1 from then on.
- R3: A `coreRxAck` pulse while `coreRxValid` is high drops `coreRxValid` at that core edge. R reads as 0 once the event has crossed to TCK. An acknowledge while `coreRxValid` is low has no effect.
- R4: A debugger write to address 0x05 while R is 1 is ignored, and `coreRxData` keeps the earlier word.
- R5: A `coreTxWrite` pulse while `coreTxBusy` is low stores `coreTxData` and raises `coreTxBusy`. W (status bit 1) reads as 1 from then on. A write pulse while busy is ignored.
- R6: An update with direction 0 and address 0x05, while W is 1, latches the core word. The next scan's capture shifts that word out on `tdo`. W clears at that update, and `coreTxBusy` falls once the event has crossed to the core clock.
- R7: A read request of address 0x05 while W is 0 returns zero and changes no flag.
- R8: A read request of address 0x04 returns a 32-bit word with W in bit 1, R in bit 0 and zeros above. Writes to 0x04 change nothing.
- R9: Any address other than 0x04 and 0x05 reads as zero. A write to such an address has no effect on either flag or on `coreRxData`.
- R10: At capture, bits 37:32 of the scan register load as zero. With `drSelect` low, the capture, shift and update strobes have no effect.
- R11: After reset, R, W, `coreRxValid`, `coreTxBusy`, `coreRxData` and `tdo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| drSelect | input | 1 | The current instruction selects this data register |
| captureDr | input | 1 | TAP is in the capture-DR state |
| shiftDr | input | 1 | TAP is in the shift-DR state |
| updateDr | input | 1 | TAP is in the update-DR state |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the scan register) |
| coreRxData | output | 32 | Word written by the debugger |
| coreRxValid | output | 1 | A debugger word is waiting for the core |
| coreRxAck | input | 1 | Core takes the waiting word (one-cycle pulse) |
| coreTxData | input | 32 | Word the core posts to the debugger |
| coreTxWrite | input | 1 | Core posts `coreTxData` (one-cycle pulse) |
| coreTxBusy | output | 1 | The posted word has not been read yet |

## Verification
Each result has a fixed due point, and the bench samples there.

- **TCK-side results:** flags and latched words change on the TCK edge of the update state. Captured bits appear on `tdo` before the first shift edge, and the bench samples `tdo` on each falling TCK edge.
- **Core-side results:** a debugger write reaches `coreRxValid` on the second or third core edge. An acknowledge or core write moves `coreRxValid` and `coreTxBusy` on the very edge that samples it, and the bench checks them on the next falling core edge.
- **Results that cross domains:** the bench waits six TCK periods before any status read or core-side check that depends on a crossing. That wait covers both synchronizer paths with margin.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  // Strobes from the TCK-side control to the scan datapath
  typedef struct packed {
    logic       loadRx;     // store data field as debugger-to-core word
    logic       latchRead;  // latch a read result for the next capture
    logic [1:0] readSel;    // which value a read latches
  } dccStrobe_t;

  localparam logic [1:0] SEL_ZERO   = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_DATA   = 2'd2;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dcc_tap_ctrl.sv
module dcc_tap_ctrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int STATUS_ADDR = 4,
  parameter int DATA_ADDR   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              drSelect,
  input  logic              updateDr,
  input  logic [ADDR_W-1:0] scanAddr,
  input  logic              scanRw,
  input  logic              txTogCore,
  input  logic              ackTogCore,
  output dccStrobe_t        strobe,
  output logic              wrTog,
  output logic              rdTog,
  output logic              flagR,
  output logic              flagW
);
  localparam logic [ADDR_W-1:0] StatusA = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] DataA   = ADDR_W'(DATA_ADDR);

  logic txTogSync, ackTogSync;

  dcc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uSyncTx (
    .clk(tck), .rstN(rstN), .din(txTogCore), .dout(txTogSync));
  dcc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uSyncAck (
    .clk(tck), .rstN(rstN), .din(ackTogCore), .dout(ackTogSync));

  // A flag is pending while the two toggles of its pair disagree
  assign flagR = wrTog ^ ackTogSync;
  assign flagW = txTogSync ^ rdTog;

  always_comb begin
    strobe = '0;
    if (drSelect && updateDr) begin
      if (scanRw) begin
        strobe.loadRx = (scanAddr == DataA) && !flagR;
      end else begin
        strobe.latchRead = 1'b1;
        if (scanAddr == StatusA)              strobe.readSel = SEL_STATUS;
        else if (scanAddr == DataA && flagW)  strobe.readSel = SEL_DATA;
        else                                  strobe.readSel = SEL_ZERO;
      end
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      wrTog <= 1'b0;
      rdTog <= 1'b0;
    end else begin
      if (strobe.loadRx) wrTog <= ~wrTog;
      if (strobe.latchRead && strobe.readSel == SEL_DATA) rdTog <= ~rdTog;
    end
  end

  AST_R_SET_AFTER_WRITE: assert property (@(posedge tck) disable iff (!rstN)
    strobe.loadRx |=> flagR); // R2
  AST_W_CLEAR_AFTER_READ: assert property (@(posedge tck) disable iff (!rstN)
    (strobe.latchRead && strobe.readSel == SEL_DATA) |=> !flagW); // R6
endmodule

// File: rtl/dcc_scan_path.sv
module dcc_scan_path
  import dcc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              drSelect,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              tdi,
  output logic              tdo,
  input  dccStrobe_t        strobe,
  input  logic              flagR,
  input  logic              flagW,
  input  logic [DATA_W-1:0] txWord,
  output logic [DATA_W-1:0] rxWord,
  output logic [ADDR_W-1:0] scanAddr,
  output logic              scanRw
);
  localparam int SCAN_W = DATA_W + ADDR_W + 1;

  logic [SCAN_W-1:0] scanReg;
  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] readNext;

  always_comb begin
    unique case (strobe.readSel)
      SEL_STATUS: readNext = {{(DATA_W-2){1'b0}}, flagW, flagR};
      SEL_DATA:   readNext = txWord;
      default:    readNext = '0;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      scanReg <= '0;
    end else if (drSelect) begin
      if (captureDr)    scanReg <= {{(SCAN_W-DATA_W){1'b0}}, readWord};
      else if (shiftDr) scanReg <= {tdi, scanReg[SCAN_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      rxWord   <= '0;
      readWord <= '0;
    end else begin
      if (strobe.loadRx)    rxWord   <= scanReg[DATA_W-1:0];
      if (strobe.latchRead) readWord <= readNext;
    end
  end

  assign tdo      = scanReg[0];
  assign scanAddr = scanReg[DATA_W +: ADDR_W];
  assign scanRw   = scanReg[SCAN_W-1];

  AST_SHIFT_ENTERS_TOP: assert property (@(posedge tck) disable iff (!rstN)
    (drSelect && shiftDr && !captureDr) |=> scanReg[SCAN_W-1] == $past(tdi)); // R1
  AST_CAPTURE_TOP_ZERO: assert property (@(posedge tck) disable iff (!rstN)
    (drSelect && captureDr) |=> scanReg[SCAN_W-1:DATA_W] == '0); // R10
  AST_RX_HELD_WHILE_FULL: assert property (@(posedge tck) disable iff (!rstN)
    flagR |=> $stable(rxWord)); // R4
endmodule

// File: rtl/dcc_core_side.sv
module dcc_core_side #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrTog,
  input  logic              rdTog,
  input  logic              coreAck,
  input  logic              coreWrite,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] txWord,
  output logic              txTog,
  output logic              ackTog,
  output logic              rxValid,
  output logic              txBusy
);
  logic wrTogSync, rdTogSync;

  dcc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uSyncWr (
    .clk(clk), .rstN(rstN), .din(wrTog), .dout(wrTogSync));
  dcc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uSyncRd (
    .clk(clk), .rstN(rstN), .din(rdTog), .dout(rdTogSync));

  assign rxValid = wrTogSync ^ ackTog;
  assign txBusy  = txTog ^ rdTogSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackTog <= 1'b0;
      txTog  <= 1'b0;
      txWord <= '0;
    end else begin
      if (coreAck && rxValid) ackTog <= ~ackTog;
      if (coreWrite && !txBusy) begin
        txTog  <= ~txTog;
        txWord <= coreWdata;
      end
    end
  end

  AST_VALID_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (coreAck && rxValid) |=> !rxValid); // R3
  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrite && !txBusy) |=> txBusy); // R5
  AST_TX_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |=> $stable(txWord)); // R5
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int STATUS_ADDR = 4,
  parameter int DATA_ADDR   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              clk,
  input  logic              rstN,
  input  logic              drSelect,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic [DATA_W-1:0] coreRxData,
  output logic              coreRxValid,
  input  logic              coreRxAck,
  input  logic [DATA_W-1:0] coreTxData,
  input  logic              coreTxWrite,
  output logic              coreTxBusy
);
  dccStrobe_t        strobe;
  logic [ADDR_W-1:0] scanAddr;
  logic              scanRw;
  logic              wrTog, rdTog, txTog, ackTog;
  logic              flagR, flagW;
  logic [DATA_W-1:0] txWord;

  dcc_tap_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .DATA_ADDR(DATA_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .tck(tck), .rstN(rstN), .drSelect(drSelect), .updateDr(updateDr),
    .scanAddr(scanAddr), .scanRw(scanRw), .txTogCore(txTog),
    .ackTogCore(ackTog), .strobe(strobe), .wrTog(wrTog), .rdTog(rdTog),
    .flagR(flagR), .flagW(flagW)
  );

  dcc_scan_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uPath (
    .tck(tck), .rstN(rstN), .drSelect(drSelect), .captureDr(captureDr),
    .shiftDr(shiftDr), .tdi(tdi), .tdo(tdo), .strobe(strobe),
    .flagR(flagR), .flagW(flagW), .txWord(txWord), .rxWord(coreRxData),
    .scanAddr(scanAddr), .scanRw(scanRw)
  );

  dcc_core_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCore (
    .clk(clk), .rstN(rstN), .wrTog(wrTog), .rdTog(rdTog),
    .coreAck(coreRxAck), .coreWrite(coreTxWrite), .coreWdata(coreTxData),
    .txWord(txWord), .txTog(txTog), .ackTog(ackTog),
    .rxValid(coreRxValid), .txBusy(coreTxBusy)
  );
endmodule

// File: tb/sim_dcc_mailbox.sv
module sim_dcc_mailbox;
  logic        tck = 1'b0;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        drSelect = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [31:0] coreRxData;
  logic        coreRxValid;
  logic        coreRxAck = 1'b0;
  logic [31:0] coreTxData = '0;
  logic        coreTxWrite = 1'b0;
  logic        coreTxBusy;

  int  errCount = 0;
  int  chkCount = 0;
  bit  finished = 0;

  always #2 clk = ~clk;   // 250 MHz core clock
  always #5 tck = ~tck;   // test clock

  dcc_mailbox u0 (
    .tck(tck), .clk(clk), .rstN(rstN), .drSelect(drSelect),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdi(tdi), .tdo(tdo), .coreRxData(coreRxData), .coreRxValid(coreRxValid),
    .coreRxAck(coreRxAck), .coreTxData(coreTxData),
    .coreTxWrite(coreTxWrite), .coreTxBusy(coreTxBusy)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One full DR pass: capture, 38 shifts, update. Returns the captured bits.
  task automatic scan(input logic [37:0] din, input logic sel, output logic [37:0] dout);
    @(negedge tck);
    drSelect = sel; captureDr = 1'b1;
    @(negedge tck);
    captureDr = 1'b0;
    for (int i = 0; i < 38; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      shiftDr = 1'b1;
      @(negedge tck);
    end
    shiftDr = 1'b0; updateDr = 1'b1;
    @(negedge tck);
    updateDr = 1'b0; drSelect = 1'b0;
  endtask

  task automatic dbgWrite(input logic [4:0] addr, input logic [31:0] data);
    logic [37:0] junk;
    scan({1'b1, addr, data}, 1'b1, junk);
  endtask

  task automatic dbgRead(input logic [4:0] addr, output logic [37:0] res);
    logic [37:0] junk;
    scan({1'b0, addr, 32'h0}, 1'b1, junk);
    scan({1'b0, 5'h00, 32'h0}, 1'b1, res);   // follow-up reads an unmapped address
  endtask

  task automatic settle();
    repeat (6) @(negedge tck);
  endtask

  task automatic coreSend(input logic [31:0] data);
    @(negedge clk);
    coreTxData = data; coreTxWrite = 1'b1;
    @(negedge clk);
    coreTxWrite = 1'b0;
  endtask

  task automatic coreTake();
    @(negedge clk);
    coreRxAck = 1'b1;
    @(negedge clk);
    coreRxAck = 1'b0;
  endtask

  task automatic readStatus(input string tag, input logic [31:0] exp);
    logic [37:0] r;
    dbgRead(5'h04, r);
    chk(tag, {26'h0, r}, {32'h0, exp});
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R11 tdo", tdo, 0);
    chk("R11 coreRxValid", coreRxValid, 0);
    chk("R11 coreTxBusy", coreTxBusy, 0);
    chk("R11 coreRxData", coreRxData, 0);
    readStatus("R11 status", 32'h0);
  endtask

  task automatic testShift();
    logic [37:0] pat = 38'h2A_5A5A_C3C3;
    logic [37:0] got;
    @(negedge tck);
    drSelect = 1'b1; captureDr = 1'b1;
    @(negedge tck);
    captureDr = 1'b0;
    for (int i = 0; i < 38; i++) begin
      tdi = pat[i]; shiftDr = 1'b1;
      @(negedge tck);
    end
    for (int i = 0; i < 38; i++) begin
      got[i] = tdo; tdi = 1'b0;
      @(negedge tck);
    end
    shiftDr = 1'b0; drSelect = 1'b0;
    chk("R1 shift through", {26'h0, got}, {26'h0, pat});
  endtask

  task automatic testWrite();
    dbgWrite(5'h05, 32'hA5C3_0F1E);
    settle();
    chk("R2 coreRxValid", coreRxValid, 1);
    chk("R2 coreRxData", coreRxData, 32'hA5C3_0F1E);
    readStatus("R2 status R", 32'h1);
    dbgWrite(5'h05, 32'h1234_5678);
    settle();
    chk("R4 data kept", coreRxData, 32'hA5C3_0F1E);
  endtask

  task automatic testAck();
    @(negedge clk);
    coreRxAck = 1'b1;
    @(negedge clk);
    coreRxAck = 1'b0;
    chk("R3 valid drops", coreRxValid, 0);
    settle();
    readStatus("R3 status clear", 32'h0);
    coreTake();   // acknowledge with nothing waiting
    dbgWrite(5'h05, 32'h0BAD_F00D);
    settle();
    chk("R3 spurious ack ignored", coreRxValid, 1);
    chk("R3 new word", coreRxData, 32'h0BAD_F00D);
    coreTake();
    settle();
  endtask

  task automatic testCoreSendRead();
    logic [37:0] r;
    coreSend(32'hCAFE_0001);
    chk("R5 busy", coreTxBusy, 1);
    coreSend(32'hDEAD_0002);   // ignored while busy
    settle();
    readStatus("R5 status W", 32'h2);
    dbgRead(5'h05, r);
    chk("R6 read word", r[31:0], 32'hCAFE_0001);
    chk("R10 capture top zero", r[37:32], 0);
    settle();
    chk("R6 busy clears", coreTxBusy, 0);
    readStatus("R6 status clear", 32'h0);
  endtask

  task automatic testReadEmpty();
    logic [37:0] r;
    dbgRead(5'h05, r);
    chk("R7 empty read zero", r[31:0], 0);
    settle();
    readStatus("R7 flags unchanged", 32'h0);
  endtask

  task automatic testStatusWrite();
    dbgWrite(5'h05, 32'h7777_0000);
    coreSend(32'h0000_8888);
    settle();
    readStatus("R8 both flags", 32'h3);
    dbgWrite(5'h04, 32'hFFFF_FFFF);
    settle();
    readStatus("R8 write ignored", 32'h3);
    chk("R8 rx data", coreRxData, 32'h7777_0000);
    coreTake();
    settle();
  endtask

  task automatic testUnmapped();
    logic [37:0] r;
    // W still set from the previous scenario
    dbgWrite(5'h07, 32'h5555_AAAA);
    settle();
    chk("R9 no rx valid", coreRxValid, 0);
    chk("R9 rx data", coreRxData, 32'h7777_0000);
    dbgRead(5'h1F, r);
    chk("R9 unmapped read", r[31:0], 0);
    settle();
    readStatus("R9 W kept", 32'h2);
    dbgRead(5'h05, r);
    chk("R6 second word", r[31:0], 32'h0000_8888);
    settle();
  endtask

  task automatic testDeselect();
    logic [37:0] junk;
    scan({1'b1, 5'h05, 32'h3C3C_3C3C}, 1'b0, junk);
    settle();
    chk("R10 deselect no write", coreRxValid, 0);
    chk("R10 deselect data", coreRxData, 32'h7777_0000);
    readStatus("R10 deselect flags", 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    rstN = 1'b1;
    testReset();
    testShift();
    testWrite();
    testAck();
    testCoreSendRead();
    testReadEmpty();
    testStatusWrite();
    testUnmapped();
    testDeselect();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end
endmodule